// File: doc/BRIEF.md
# Two-level interrupt aggregator

This block gathers event pulses from several groups of sources into a single active-low interrupt line. Each pulse sets a sticky secondary status bit. A secondary bit stays set until the host clears it. Each group has a per-bit enable mask. A group is pending when at least one of its bits is both set and enabled. The pending flags of all groups form a read-only primary status register. The primary register has its own enable mask. The host sees the interrupt when any enabled primary bit is pending.

The host works through a byte-wide register port with a select, a write flag, an 8-bit address, write data and combinational read data. It finds the source in two reads. First it reads the primary status to learn which group is pending. Then it reads that group's status. It clears the bits it has served by writing ones to them.

The register map is as follows:
- `0x00` is the primary status, read-only, with bit g standing for group g.
- `0x01` is the primary enable.
- `0x10 + 2*g` is the status of group g, cleared by writing ones.
- `0x11 + 2*g` is the enable of group g.

All other addresses are reserved. Event input bit `g*GROUP_W + b` drives bit b of group g.

Top module: `irq_hier_agg`

## Requirements
- R1: A one-cycle high on an event input sets the matching group status bit at the next rising clock edge. The bit then stays set after the pulse ends, until the host clears it.
- R2: A write to a group status address (`0x10 + 2*g`) clears each bit written as 1. Bits written as 0 keep their value.
- R3: When an event arrives in the same cycle as a clearing write to the same bit, the bit ends up set.
- R4: Bit g of the primary status (`0x00`) reads 1 exactly when group g has a bit that is both set and enabled in that group's enable (`0x11 + 2*g`).
- R5: Writes to the primary status address change no register.
- R6: `irq_n` is low exactly when some primary status bit is set and its primary enable bit (`0x01`) is set. `irq_n` is registered, so it follows that condition one clock edge later.
- R7: A group enable bit of 0 does not stop the matching status bit from being captured. It only keeps that bit out of the primary status.
- R8: After reset, all status and enable registers read 0 and `irq_n` is high. Enable registers read back the value written. Primary enable bits at or above `NUM_GROUPS` read 0.
- R9: Reserved addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt | input | NUM_GROUPS*GROUP_W | Event pulses; bit g*GROUP_W+b feeds group g bit b |
| host_sel | input | 1 | Register access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Register byte address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from the address during a read |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
The bound checker watches several rules on every cycle:
- capture of every event (R1);
- persistence of every uncleared status bit (R1);
- clearing by ones (R2);
- event priority over a coinciding clear (R3);
- the one-edge relation between the enabled pending groups and `irq_n` (R6);
- zero read data at reserved addresses (R9).

The directed scenarios are needed for other behaviours. They show that writes to the primary status and to reserved addresses leave every register as it was, and that enable registers read back what was written. They also show that the reset values hold, and that a masked bit is still captured yet hidden from the primary level. These checks compare register contents before and after an access, which no single-cycle property covers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int unsigned HOST_AW = 8;
   localparam int unsigned HOST_DW = 8;

   localparam logic [HOST_AW-1:0] ADR_PRIM_STS = 8'h00;
   localparam logic [HOST_AW-1:0] ADR_PRIM_EN  = 8'h01;
   localparam logic [HOST_AW-1:0] ADR_GRP_BASE = 8'h10;

   // status of group g sits at an even offset, its enable right after it
   function automatic logic [HOST_AW-1:0] grp_sts_adr(input int unsigned g);
      return ADR_GRP_BASE + HOST_AW'(2 * g);
   endfunction

   function automatic logic [HOST_AW-1:0] grp_en_adr(input int unsigned g);
      return ADR_GRP_BASE + HOST_AW'(2 * g + 1);
   endfunction

endpackage

// File: rtl/irq_sec_group.sv
module irq_sec_group #(
   parameter int unsigned GROUP_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [GROUP_W-1:0] evt,
   input  logic [GROUP_W-1:0] clr_mask,
   input  logic               en_we,
   input  logic [GROUP_W-1:0] en_wdata,
   output logic [GROUP_W-1:0] sts,
   output logic [GROUP_W-1:0] en,
   output logic               pend
);

   logic [GROUP_W-1:0] sts_q;
   logic [GROUP_W-1:0] en_q;

   // sticky capture; a new event wins over a clear in the same cycle
   for (genvar b = 0; b < GROUP_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         sts_q[b] <= 1'b0;
         else if (evt[b])    sts_q[b] <= 1'b1;
         else if (clr_mask[b]) sts_q[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata;
   end

   assign sts  = sts_q;
   assign en   = en_q;
   assign pend = |(sts_q & en_q);

endmodule

// File: rtl/irq_prim_level.sv
module irq_prim_level #(
   parameter int unsigned NUM_GROUPS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_GROUPS-1:0] grp_pend,
   input  logic                  en_we,
   input  logic [NUM_GROUPS-1:0] en_wdata,
   output logic [NUM_GROUPS-1:0] prim_sts,
   output logic [NUM_GROUPS-1:0] prim_en,
   output logic                  irq_n
);

   logic [NUM_GROUPS-1:0] en_q;
   logic                  irq_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata;
   end

   // registered output: no glitch from the OR tree reaches the pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~|(grp_pend & en_q);
   end

   assign prim_sts = grp_pend;
   assign prim_en  = en_q;
   assign irq_n    = irq_n_q;

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GROUP_W    = 8,
   localparam int unsigned FLAT_W    = NUM_GROUPS * GROUP_W
) (
   input  logic                  host_sel,
   input  logic                  host_we,
   input  logic [HOST_AW-1:0]    host_addr,
   input  logic [HOST_DW-1:0]    host_wdata,
   input  logic [FLAT_W-1:0]     sts_flat,
   input  logic [FLAT_W-1:0]     en_flat,
   input  logic [NUM_GROUPS-1:0] prim_sts,
   input  logic [NUM_GROUPS-1:0] prim_en,
   output logic [FLAT_W-1:0]     clr_flat,
   output logic [NUM_GROUPS-1:0] sec_en_we,
   output logic                  prim_en_we,
   output logic [GROUP_W-1:0]    grp_wdata,
   output logic [NUM_GROUPS-1:0] prim_wdata,
   output logic [HOST_DW-1:0]    host_rdata
);

   logic wr;
   logic rd;

   assign wr         = host_sel & host_we;
   assign rd         = host_sel & ~host_we;
   assign grp_wdata  = host_wdata[GROUP_W-1:0];
   assign prim_wdata = host_wdata[NUM_GROUPS-1:0];
   assign prim_en_we = wr && (host_addr == ADR_PRIM_EN);

   always_comb begin
      clr_flat   = '0;
      sec_en_we  = '0;
      host_rdata = '0;
      if (rd && host_addr == ADR_PRIM_STS) host_rdata = HOST_DW'(prim_sts);
      if (rd && host_addr == ADR_PRIM_EN)  host_rdata = HOST_DW'(prim_en);
      for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
         if (host_addr == grp_sts_adr(g)) begin
            if (rd) host_rdata = HOST_DW'(sts_flat[g*GROUP_W +: GROUP_W]);
            if (wr) clr_flat[g*GROUP_W +: GROUP_W] = grp_wdata;
         end
         if (host_addr == grp_en_adr(g)) begin
            if (rd) host_rdata = HOST_DW'(en_flat[g*GROUP_W +: GROUP_W]);
            if (wr) sec_en_we[g] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irq_hier_agg.sv
module irq_hier_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GROUP_W    = 8,
   localparam int unsigned FLAT_W    = NUM_GROUPS * GROUP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FLAT_W-1:0]  evt,
   input  logic               host_sel,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic [HOST_DW-1:0] host_rdata,
   output logic               irq_n
);

   if (NUM_GROUPS < 1 || NUM_GROUPS > HOST_DW) begin : g_bad_groups
      $error("NUM_GROUPS must fit one primary byte");
   end
   if (GROUP_W < 1 || GROUP_W > HOST_DW) begin : g_bad_width
      $error("GROUP_W must fit one data byte");
   end
   if (int'(ADR_GRP_BASE) + 2 * NUM_GROUPS > (1 << HOST_AW)) begin : g_bad_map
      $error("group registers overrun the address space");
   end

   logic [FLAT_W-1:0]     sts_flat;
   logic [FLAT_W-1:0]     en_flat;
   logic [FLAT_W-1:0]     clr_flat;
   logic [NUM_GROUPS-1:0] sec_en_we;
   logic [NUM_GROUPS-1:0] grp_pend;
   logic [NUM_GROUPS-1:0] prim_sts;
   logic [NUM_GROUPS-1:0] prim_en;
   logic                  prim_en_we;
   logic [GROUP_W-1:0]    grp_wdata;
   logic [NUM_GROUPS-1:0] prim_wdata;

   irq_reg_decode #(
      .NUM_GROUPS(NUM_GROUPS),
      .GROUP_W   (GROUP_W)
   ) dec_i (
      .host_sel  (host_sel),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .sts_flat  (sts_flat),
      .en_flat   (en_flat),
      .prim_sts  (prim_sts),
      .prim_en   (prim_en),
      .clr_flat  (clr_flat),
      .sec_en_we (sec_en_we),
      .prim_en_we(prim_en_we),
      .grp_wdata (grp_wdata),
      .prim_wdata(prim_wdata),
      .host_rdata(host_rdata)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      irq_sec_group #(
         .GROUP_W(GROUP_W)
      ) grp_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (evt[g*GROUP_W +: GROUP_W]),
         .clr_mask(clr_flat[g*GROUP_W +: GROUP_W]),
         .en_we   (sec_en_we[g]),
         .en_wdata(grp_wdata),
         .sts     (sts_flat[g*GROUP_W +: GROUP_W]),
         .en      (en_flat[g*GROUP_W +: GROUP_W]),
         .pend    (grp_pend[g])
      );
   end

   irq_prim_level #(
      .NUM_GROUPS(NUM_GROUPS)
   ) prim_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .grp_pend(grp_pend),
      .en_we   (prim_en_we),
      .en_wdata(prim_wdata),
      .prim_sts(prim_sts),
      .prim_en (prim_en),
      .irq_n   (irq_n)
   );

endmodule

// File: rtl/irq_hier_agg_chk.sv
module irq_hier_agg_chk
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GROUP_W    = 8,
   localparam int unsigned FLAT_W    = NUM_GROUPS * GROUP_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [FLAT_W-1:0]     evt,
   input logic                  host_sel,
   input logic                  host_we,
   input logic [HOST_AW-1:0]    host_addr,
   input logic [HOST_DW-1:0]    host_wdata,
   input logic [HOST_DW-1:0]    host_rdata,
   input logic                  irq_n,
   input logic [FLAT_W-1:0]     sts_flat,
   input logic [NUM_GROUPS-1:0] prim_sts,
   input logic [NUM_GROUPS-1:0] prim_en
);

   logic [FLAT_W-1:0] clr_req;
   logic              rsv_rd;

   // host-side view of which status bits a write asks to clear
   always_comb begin
      clr_req = '0;
      rsv_rd  = host_sel && !host_we
                && host_addr != ADR_PRIM_STS && host_addr != ADR_PRIM_EN;
      for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
         if (host_sel && host_we && host_addr == grp_sts_adr(g))
            clr_req[g*GROUP_W +: GROUP_W] = host_wdata[GROUP_W-1:0];
         if (host_addr == grp_sts_adr(g) || host_addr == grp_en_adr(g))
            rsv_rd = 1'b0;
      end
   end

   assert_evt_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt) & ~sts_flat) == '0));

   assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(sts_flat) & ~$past(clr_req) & ~sts_flat) == '0));

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr_req) & ~$past(evt) & sts_flat) == '0));

   assert_evt_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & clr_req)) |=> (($past(evt & clr_req) & ~sts_flat) == '0));

   assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_n == !$past(|(prim_sts & prim_en))));

   assert_rsv_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_rd |-> (host_rdata == '0));

endmodule

bind irq_hier_agg irq_hier_agg_chk #(
   .NUM_GROUPS(NUM_GROUPS),
   .GROUP_W   (GROUP_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt       (evt),
   .host_sel  (host_sel),
   .host_we   (host_we),
   .host_addr (host_addr),
   .host_wdata(host_wdata),
   .host_rdata(host_rdata),
   .irq_n     (irq_n),
   .sts_flat  (sts_flat),
   .prim_sts  (prim_sts),
   .prim_en   (prim_en)
);

// File: tb/irq_hier_agg_tb.sv
module irq_hier_agg_tb_top;

   localparam int unsigned NG       = 4;
   localparam int unsigned GW       = 8;
   localparam time         CLK_PER  = 10ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NG*GW-1:0] evt = '0;
   logic           host_sel = 1'b0;
   logic           host_we = 1'b0;
   logic [7:0]     host_addr = '0;
   logic [7:0]     host_wdata = '0;
   logic [7:0]     host_rdata;
   logic           irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   irq_hier_agg #(.NUM_GROUPS(NG), .GROUP_W(GW)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_n(irq_n)
   );

   function automatic logic [7:0] sts_a(int g); return 8'h10 + 8'(2*g); endfunction
   function automatic logic [7:0] en_a(int g);  return 8'h11 + 8'(2*g); endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0;
   endtask

   task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b0; host_addr = a;
      #1;
      check(req, host_rdata, exp);
      host_sel = 1'b0;
   endtask

   task automatic pulse(int g, int b);
      @(negedge clk);
      evt[g*GW + b] = 1'b1;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic t_reset();
      check("R8 irq_n after reset", {7'd0, irq_n}, 8'h01);
      rd_chk(8'h00, 8'h00, "R8 primary status reset");
      rd_chk(8'h01, 8'h00, "R8 primary enable reset");
      for (int g = 0; g < NG; g++) begin
         rd_chk(sts_a(g), 8'h00, "R8 group status reset");
         rd_chk(en_a(g),  8'h00, "R8 group enable reset");
      end
   endtask

   task automatic t_capture_masked();
      pulse(1, 3);
      repeat (3) @(negedge clk);
      rd_chk(sts_a(1), 8'h08, "R1 R7 sticky capture while masked");
      rd_chk(8'h00, 8'h00, "R7 masked bit absent from primary");
      check("R7 irq_n high while masked", {7'd0, irq_n}, 8'h01);
   endtask

   task automatic t_enables();
      wr(en_a(1), 8'hA8);
      rd_chk(en_a(1), 8'hA8, "R8 group enable readback");
      rd_chk(8'h00, 8'h02, "R4 primary shows group 1");
      check("R6 irq_n high with primary mask off", {7'd0, irq_n}, 8'h01);
      wr(8'h01, 8'hFF);
      check("R6 irq_n one edge late", {7'd0, irq_n}, 8'h01);
      @(negedge clk);
      check("R6 irq_n asserted", {7'd0, irq_n}, 8'h00);
      rd_chk(8'h01, 8'h0F, "R8 primary enable upper bits read 0");
   endtask

   task automatic t_prim_ro();
      wr(8'h00, 8'h00);
      rd_chk(8'h00, 8'h02, "R5 primary write 0 ignored");
      wr(8'h00, 8'hFF);
      rd_chk(8'h00, 8'h02, "R5 primary write 1 ignored");
      rd_chk(8'h01, 8'h0F, "R5 primary enable untouched");
      rd_chk(sts_a(1), 8'h08, "R5 group status untouched");
   endtask

   task automatic t_w1c();
      pulse(1, 5);
      rd_chk(sts_a(1), 8'h28, "R1 second bit captured");
      wr(sts_a(1), 8'h20);
      rd_chk(sts_a(1), 8'h08, "R2 clear one bit");
      wr(sts_a(1), 8'h00);
      rd_chk(sts_a(1), 8'h08, "R2 zero write keeps bits");
      check("R6 irq_n still low", {7'd0, irq_n}, 8'h00);
      wr(sts_a(1), 8'h08);
      rd_chk(sts_a(1), 8'h00, "R2 clear last bit");
      rd_chk(8'h00, 8'h00, "R4 primary drops after clear");
      check("R6 irq_n high in same negedge as rd", {7'd0, irq_n}, 8'h01);
   endtask

   task automatic t_collide();
      pulse(2, 0);
      rd_chk(sts_a(2), 8'h01, "R1 group 2 bit 0 set");
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = sts_a(2); host_wdata = 8'h01;
      evt[2*GW] = 1'b1;
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0; evt = '0;
      rd_chk(sts_a(2), 8'h01, "R3 event wins over clear");
   endtask

   task automatic t_reserved();
      wr(8'h05, 8'hFF);
      wr(8'h30, 8'hFF);
      rd_chk(8'h05, 8'h00, "R9 reserved 0x05 reads 0");
      rd_chk(8'h30, 8'h00, "R9 reserved 0x30 reads 0");
      rd_chk(8'h02, 8'h00, "R9 reserved 0x02 reads 0");
      rd_chk(sts_a(2), 8'h01, "R9 status untouched");
      rd_chk(en_a(2), 8'h00, "R9 enable untouched");
      rd_chk(8'h01, 8'h0F, "R9 primary enable untouched");
   endtask

   task automatic t_prim_mask();
      wr(en_a(2), 8'h01);
      wr(8'h01, 8'h0B);
      @(negedge clk);
      rd_chk(8'h00, 8'h04, "R4 group 2 pending");
      check("R6 primary mask blocks irq", {7'd0, irq_n}, 8'h01);
      wr(8'h01, 8'h04);
      @(negedge clk);
      check("R6 primary mask opens irq", {7'd0, irq_n}, 8'h00);
      wr(en_a(2), 8'h00);
      @(negedge clk);
      check("R6 group mask drops irq", {7'd0, irq_n}, 8'h01);
      rd_chk(sts_a(2), 8'h01, "R7 status kept when group mask off");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capture_masked();
      t_enables();
      t_prim_ro();
      t_w1c();
      t_collide();
      t_reserved();
      t_prim_mask();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PER * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule